// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block generates the horizontal sync, vertical sync and field-parity strobes for an interlaced raster. It runs from the double-rate pixel clock. A pixel counter walks each line. A second counter advances twice per line, once at the line start and once at the half-line point, and wraps after one full frame of two fields. The sync outputs are active low. The field flag is low for the odd field and high for the even field.

A one-bit standard select picks between two raster families. Family 0 is 525 lines at 59.94 fields per second, and its vertical pulse lasts three lines. Family 1 is 625 lines at 50 fields per second, and its vertical pulse lasts two and a half lines. Both line counts are odd, so the even-field vertical pulse starts in the middle of a line, while the odd-field pulse starts together with a horizontal pulse. The field flag changes a fixed number of clocks before every vertical leading edge, so downstream logic sees the new parity before the pulse arrives. The select input is captured during reset and again on the last clock of each frame. A frame already in progress always completes with the family it started with.

Top module: `interlaced_sync_gen`

## Requirements
- R1: While reset (active low, synchronous) is applied, hsync_n and vsync_n are 1 and field is 0 from the first clock edge on.
- R2: hsync_n falls once every line period: LINE_A clocks when std_sel selected 0 (525 family) and LINE_B clocks when it selected 1 (625 family).
- R3: Each hsync_n low pulse lasts HS_A clocks (family 0) or HS_B clocks (family 1).
- R4: In the odd field (field = 0), vsync_n falls in the same cycle as hsync_n.
- R5: In the even field (field = 1), vsync_n falls half a line period after the latest hsync_n fall, while hsync_n is high.
- R6: vsync_n stays low for VS_HALF_A half-lines (6, three lines) in family 0 and for VS_HALF_B half-lines (5, two and a half lines) in family 1.
- R7: field changes exactly LEAD clocks before each vsync_n falling edge. It goes to 0 before the odd-field edge and to 1 before the even-field edge, and it never changes while vsync_n is low.
- R8: std_sel is sampled only during reset and on the last clock of a frame. A change at any other time has no effect on the outputs until the next frame starts.
- R9: Consecutive odd-field vsync_n falls are one frame apart: LINES_A × LINE_A clocks in family 0 and LINES_B × LINE_B clocks in family 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| std_sel | input | 1 | Raster family: 0 = 525-line, 1 = 625-line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field | output | 1 | Field parity: 0 odd, 1 even |

## Verification
A pixel counter that has slipped moves the hsync_n edge or changes its width. That appears on the very next line, and the reference comparison catches it in the first cycle that differs. A half-line counter that is off by one moves the vertical edge by half a line, or turns a mid-line even-field edge into a line-aligned one. It also shifts the field-to-vsync lead, so it shows up at the next vertical pulse, within one field. A wrongly latched family changes the line period and the frame length from the next frame boundary on. The bench therefore changes the select input in mid-frame and checks that nothing changes until the wrap.

// File: rtl/interlaced_sync_gen.sv
module interlaced_sync_gen #(
  parameter int LINE_A    = 1716,
  parameter int LINE_B    = 1728,
  parameter int LINES_A   = 525,
  parameter int LINES_B   = 625,
  parameter int HS_A      = 127,
  parameter int HS_B      = 127,
  parameter int VS_HALF_A = 6,
  parameter int VS_HALF_B = 5,
  parameter int LEAD      = 32
) (
  input  logic clk2,
  input  logic rst_n,
  input  logic std_sel,
  output logic hsync_n,
  output logic vsync_n,
  output logic field
);
  localparam int LMAX = (LINE_A > LINE_B) ? LINE_A : LINE_B;
  localparam int NMAX = 2 * ((LINES_A > LINES_B) ? LINES_A : LINES_B);
  localparam int HW   = $clog2(LMAX + 1);
  localparam int VW   = $clog2(NMAX + 1);

  logic          std_q;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vhl;

  logic [HW-1:0] llen, half, hsw, lead;
  logic [VW-1:0] nl, last_hl, vsw;
  logic          line_end, mid_line, frame_end;
  logic          hs_act, vs_act, hit_odd, hit_even;

  assign llen    = std_q ? HW'(LINE_B) : HW'(LINE_A);
  assign hsw     = std_q ? HW'(HS_B) : HW'(HS_A);
  assign half    = llen >> 1;
  assign lead    = HW'(LEAD);
  assign nl      = std_q ? VW'(LINES_B) : VW'(LINES_A);
  assign vsw     = std_q ? VW'(VS_HALF_B) : VW'(VS_HALF_A);
  assign last_hl = (nl << 1) - 1'b1;

  assign line_end  = (hpos == llen - 1'b1);
  assign mid_line  = (hpos == half - 1'b1);
  assign frame_end = line_end && (vhl == last_hl);

  assign hs_act   = (hpos < hsw);
  assign vs_act   = (vhl < vsw) || ((vhl >= nl) && (vhl < nl + vsw));
  assign hit_odd  = (vhl == last_hl) && (hpos == llen - lead);
  assign hit_even = (vhl == nl - 1'b1) && (hpos == half - lead);

  always_ff @(posedge clk2) begin
    if (!rst_n) begin
      std_q <= std_sel;
      hpos  <= '0;
      vhl   <= '0;
    end else begin
      hpos <= line_end ? '0 : hpos + 1'b1;
      if (frame_end) begin
        vhl   <= '0;
        std_q <= std_sel;
      end else if (line_end || mid_line) begin
        vhl <= vhl + 1'b1;
      end
    end
  end

  always_ff @(posedge clk2) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      field   <= 1'b0;
    end else begin
      hsync_n <= !hs_act;
      vsync_n <= !vs_act;
      if (hit_odd)       field <= 1'b0;
      else if (hit_even) field <= 1'b1;
    end
  end
endmodule

// File: rtl/interlaced_sync_gen_chk.sv
module interlaced_sync_gen_chk #(
  parameter int HS_A = 127,
  parameter int HS_B = 127
) (
  input logic clk2,
  input logic rst_n,
  input logic hsync_n,
  input logic vsync_n,
  input logic field,
  input logic std_q
);
  int hs_low;

  always_ff @(posedge clk2) begin
    if (!rst_n)        hs_low <= 0;
    else if (!hsync_n) hs_low <= hs_low + 1;
    else               hs_low <= 0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk2)
    !rst_n |=> (hsync_n && vsync_n && !field)); // R1

  AST_HS_WIDTH: assert property (@(posedge clk2) disable iff (!rst_n)
    $rose(hsync_n) |-> (hs_low == (std_q ? HS_B : HS_A))); // R3

  AST_ODD_ALIGN: assert property (@(posedge clk2) disable iff (!rst_n)
    ($fell(vsync_n) && !field) |-> $fell(hsync_n)); // R4

  AST_EVEN_MIDLINE: assert property (@(posedge clk2) disable iff (!rst_n)
    ($fell(vsync_n) && field) |-> hsync_n); // R5

  AST_FIELD_OUTSIDE_VS: assert property (@(posedge clk2) disable iff (!rst_n)
    !$stable(field) |-> vsync_n); // R7
endmodule

bind interlaced_sync_gen interlaced_sync_gen_chk #(.HS_A(HS_A), .HS_B(HS_B)) u_chk (
  .clk2(clk2), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .field(field), .std_q(std_q)
);

// File: tb/sim_interlaced_sync_gen.sv
module sim_interlaced_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LA = 40, LB = 48, NA = 11, NB = 13;
  localparam int HA = 6, HB = 7, VA = 6, VB = 5, LD = 4;

  logic clk = 0, rst_n = 0, std_sel = 0;
  logic hsync_n, vsync_n, field;

  interlaced_sync_gen #(.LINE_A(LA), .LINE_B(LB), .LINES_A(NA), .LINES_B(NB),
    .HS_A(HA), .HS_B(HB), .VS_HALF_A(VA), .VS_HALF_B(VB), .LEAD(LD)) u0 (
    .clk2(clk), .rst_n(rst_n), .std_sel(std_sel),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .field(field));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int llen(input bit s); return s ? LB : LA; endfunction
  function automatic int nlin(input bit s); return s ? NB : NA; endfunction

  // reference model
  int mf = 0;
  bit mstd = 0;
  bit e_hs = 1, e_vs = 1, e_fd = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mstd = std_sel; mf = 0; e_hs = 1; e_vs = 1; e_fd = 0;
    end else begin
      int l, n, h, e, w, fr;
      l = llen(mstd); n = nlin(mstd); h = mstd ? HB : HA;
      w = (mstd ? VB : VA) * (l / 2);
      e = n * (l / 2); fr = n * l;
      e_hs = !((mf % l) < h);
      e_vs = !((mf < w) || (mf >= e && mf < e + w));
      e_fd = (mf >= e - LD) && (mf < fr - LD);
      mf++;
      if (mf == fr) begin mf = 0; mstd = std_sel; end
    end
  end

  // per-cycle comparison and event checks
  int cyc = 0, hs_fall = 0, vs_fall = 0, odd_fall = 0, fchg = 0;
  bit have_hs = 0, have_odd = 0, have_fchg = 0, fstd = 0, lstd = 0;
  logic p_hs = 1, p_vs = 1, p_fd = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; have_hs = 0; have_odd = 0; have_fchg = 0;
      p_hs = 1; p_vs = 1; p_fd = 0;
    end else begin
      cyc++;
      chk(hsync_n === e_hs, "R2/R3 hsync_n", hsync_n, e_hs);
      chk(vsync_n === e_vs, "R4/R5/R6/R8 vsync_n", vsync_n, e_vs);
      chk(field === e_fd, "R7 field", field, e_fd);
      if (field !== p_fd) begin fchg = cyc; have_fchg = 1; end
      if (p_vs && !vsync_n) begin
        if (!field) begin
          chk(p_hs && !hsync_n, "R4 odd vsync with hsync", hsync_n, 0);
          if (have_odd) chk(cyc - odd_fall == nlin(fstd) * llen(fstd),
                            "R9 frame period", cyc - odd_fall, nlin(fstd) * llen(fstd));
          odd_fall = cyc; have_odd = 1; fstd = mstd;
        end else begin
          chk(hsync_n === 1'b1 && cyc - hs_fall == llen(fstd) / 2,
              "R5 even vsync mid-line", cyc - hs_fall, llen(fstd) / 2);
        end
        if (have_fchg) chk(cyc - fchg == LD, "R7 field lead", cyc - fchg, LD);
        vs_fall = cyc;
      end
      if (!p_vs && vsync_n)
        chk(cyc - vs_fall == (fstd ? VB : VA) * (llen(fstd) / 2),
            "R6 vsync width", cyc - vs_fall, (fstd ? VB : VA) * (llen(fstd) / 2));
      if (p_hs && !hsync_n) begin
        if (have_hs) chk(cyc - hs_fall == llen(lstd), "R2 line period",
                         cyc - hs_fall, llen(lstd));
        hs_fall = cyc; have_hs = 1; lstd = fstd;
        if (!vsync_n && p_vs && !field) lstd = mstd;
      end
      if (!p_hs && hsync_n)
        chk(cyc - hs_fall == (lstd ? HB : HA), "R3 hsync width",
            cyc - hs_fall, lstd ? HB : HA);
      p_hs = hsync_n; p_vs = vsync_n; p_fd = field;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_check(input bit s);
    @(negedge clk); rst_n = 0; std_sel = s;
    run(4);
    chk(hsync_n === 1'b1, "R1 reset hsync_n", hsync_n, 1);
    chk(vsync_n === 1'b1, "R1 reset vsync_n", vsync_n, 1);
    chk(field === 1'b0, "R1 reset field", field, 0);
    rst_n = 1;
  endtask

  initial begin
    reset_check(0);
    run(1000);
    std_sel = 1;            // R8: takes effect only at the frame wrap
    run(1500);
    std_sel = 0; run(3); std_sel = 1;  // R8: brief mid-frame change ignored
    run(1000);
    std_sel = 0;
    run(1500);
    reset_check(1);         // R1, R8: family captured during reset
    run(2000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule